// File: doc/BRIEF.md
# I2S Stereo-to-Dual-Mono Splitter

This block receives one stereo I2S stream and produces two I2S streams that share one bit clock and one word-select line. The first output repeats the left sample of each frame in both of its slots. The second output repeats the right sample in both of its slots. Each output can therefore feed one stereo DAC wired for mono operation, and both DACs stay in step.

The serial lines are brought into a fast system clock through a short synchronizer, and edges of the incoming bit clock are detected there. Each incoming 16-bit word is shifted into a per-channel capture register. When the right slot of a frame ends, both words are copied into holding registers. During the following frame those words are shifted out again on both outputs. The outputs are standard I2S: word select is low for left and high for right, and the MSB comes one bit clock after each word-select change. The output framing trails the input by exactly one frame plus one bit clock.

Top module: `i2s_mono_split`

## Requirements
- R1: In every output frame, `sd_lmono_o` carries the same 16-bit left word in its left slot and in its right slot, MSB first. Framing is I2S: `ws_o` low marks the left slot, high marks the right slot, and the MSB sits in the bit period after the `ws_o` change.
- R2: In every output frame, `sd_rmono_o` carries the same 16-bit right word in both of its slots, using the framing of R1. A left word never appears on this output, and a right word never appears on `sd_lmono_o`.
- R3: The words carried by output frame n+1 are the words captured from input frame n. Each output slot starts one bit clock after the matching input slot.
- R4: `bck_o` is `bck_i` delayed through the input synchronizer. `ws_o`, `sd_lmono_o` and `sd_rmono_o` change only in the system-clock cycle in which `bck_o` falls.
- R5: Bits that follow the first 16 bits of an input slot are ignored. On both outputs, every bit position after the 16th in a slot is driven as 0.
- R6: While reset is asserted and after it is released, `bck_o`, `ws_o` and both data outputs are 0. Both outputs then carry zero samples until one full input frame has been captured, starting from an observed left-slot start.
- R7: Slots that are exactly 16 bit clocks long (32 bit clocks per frame) work on input and output. In such a slot, the LSB falls in the bit period in which word select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Incoming I2S bit clock |
| ws_i | input | 1 | Incoming word select (0 = left, 1 = right) |
| sd_i | input | 1 | Incoming serial data, MSB first |
| bck_o | output | 1 | Bit clock shared by both outputs |
| ws_o | output | 1 | Word select shared by both outputs |
| sd_lmono_o | output | 1 | Serial data carrying the left word in both slots |
| sd_rmono_o | output | 1 | Serial data carrying the right word in both slots |

## Verification
The main function is driven with random stereo frames in 16-bit slots. It is also driven with fixed corner words in 32-bit slots: a lone MSB, a lone LSB, all ones against all zeros, and complementary alternating patterns. Because left and right always differ in these frames, a swapped channel, a dropped or doubled bit, or a one-bit misalignment of the MSB shows up as a wrong decoded word.

Exact 16-bit slots test the case where the LSB shares the word-select change. 24-bit slots whose padding bits are all ones show whether padding leaks into the captured word or onto the outputs. The first output frame of every run must decode as zeros, and every later frame must hold the previous input frame. This separates a correct one-frame latency from a zero-frame or two-frame one.

// File: rtl/i2s_split_pkg.sv
package i2s_split_pkg;

    // Default sample length and synchronizer depth
    localparam int DEF_WORD_W      = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // Slot identity as carried on word select
    typedef enum logic {
        SLOT_LEFT  = 1'b0,
        SLOT_RIGHT = 1'b1
    } slot_e;

    // The three incoming serial lines, sampled together
    typedef struct packed {
        logic bck;
        logic ws;
        logic sd;
    } line_t;

    // Bit-clock edge pulses, one system-clock cycle wide
    typedef struct packed {
        logic rise;
        logic fall;
    } bck_edge_t;

    // Width of a counter that must reach n (saturating slot position)
    function automatic int pos_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/i2s_split_sync.sv
module i2s_split_sync
    import i2s_split_pkg::*;
#(
    parameter int STAGES = DEF_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  line_t     line_i,
    output logic      ws_o,
    output logic      sd_o,
    output bck_edge_t edge_o,
    output logic      bck_d_o
);

    line_t stg [STAGES];
    logic  bck_prev;

    // Plain flop chain; all three lines see identical delay
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) begin
                stg[k] <= '0;
            end
            bck_prev <= 1'b0;
        end else begin
            stg[0] <= line_i;
            for (int k = 1; k < STAGES; k++) begin
                stg[k] <= stg[k-1];
            end
            bck_prev <= stg[STAGES-1].bck;
        end
    end

    assign ws_o        = stg[STAGES-1].ws;
    assign sd_o        = stg[STAGES-1].sd;
    assign edge_o.rise = stg[STAGES-1].bck & ~bck_prev;
    assign edge_o.fall = ~stg[STAGES-1].bck & bck_prev;
    assign bck_d_o     = bck_prev;

endmodule

// File: rtl/i2s_split_rx.sv
module i2s_split_rx
    import i2s_split_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W,
    parameter int POS_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    input  logic              ws_i,
    input  logic              sd_i,
    output logic [WORD_W-1:0] hold_l_o,
    output logic [WORD_W-1:0] hold_r_o,
    output logic              latch_o,
    output slot_e             slot_o
);

    localparam logic [POS_W-1:0] POS_END = POS_W'(WORD_W);
    localparam logic [POS_W-1:0] POS_ONE = POS_W'(1);

    logic              primed;     // word select seen at least once
    logic              lstart;     // a left-slot start has been observed
    slot_e             slot_q;     // slot of the bit sampled at this rise
    logic [POS_W-1:0]  pos_q;      // bit index inside that slot, saturating
    logic [WORD_W-1:0] cap_l, cap_r;
    logic [WORD_W-1:0] cap_l_nx, cap_r_nx;
    logic              chg, in_word, frame_end;

    // The bit sampled at a rise belongs to the slot named by the
    // previous word select, so slot_q decides where it goes.
    assign chg       = primed & (slot_e'(ws_i) != slot_q);
    assign in_word   = pos_q < POS_END;
    assign frame_end = rise_i & chg & (slot_q == SLOT_RIGHT);
    assign latch_o   = frame_end & lstart;

    always_comb begin
        cap_l_nx = cap_l;
        cap_r_nx = cap_r;
        if (in_word) begin
            if (slot_q == SLOT_LEFT) begin
                cap_l_nx = {cap_l[WORD_W-2:0], sd_i};
            end else begin
                cap_r_nx = {cap_r[WORD_W-2:0], sd_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            lstart   <= 1'b0;
            slot_q   <= SLOT_LEFT;
            pos_q    <= POS_END;
            cap_l    <= '0;
            cap_r    <= '0;
            hold_l_o <= '0;
            hold_r_o <= '0;
        end else if (rise_i) begin
            slot_q <= slot_e'(ws_i);
            if (!primed) begin
                primed <= 1'b1;
                pos_q  <= POS_END;
            end else begin
                cap_l <= cap_l_nx;
                cap_r <= cap_r_nx;
                if (chg) begin
                    pos_q <= '0;
                end else if (pos_q != POS_END) begin
                    pos_q <= pos_q + POS_ONE;
                end
                if (frame_end) begin
                    lstart <= 1'b1;
                end
                if (latch_o) begin
                    hold_l_o <= cap_l_nx;
                    hold_r_o <= cap_r_nx;
                end
            end
        end
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/i2s_split_tx.sv
module i2s_split_tx
    import i2s_split_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sd_o
);

    logic [WORD_W-1:0] shreg;

    // At a slot-change fall the old slot's last bit is sent first,
    // then the new word is loaded so its MSB follows one bit later.
    // Zeros shift in behind the word, so padding bits go out as 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            sd_o  <= 1'b0;
        end else if (fall_i) begin
            sd_o <= shreg[WORD_W-1];
            if (load_i) begin
                shreg <= word_i;
            end else begin
                shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/i2s_mono_split.sv
module i2s_mono_split
    import i2s_split_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bck_o,
    output logic ws_o,
    output logic sd_lmono_o,
    output logic sd_rmono_o
);

    localparam int POS_W   = pos_width(WORD_W);
    localparam int N_OUTS  = 2;

    line_t                        line_in;
    logic                         ws_s, sd_s;
    bck_edge_t                    bedge;
    logic [WORD_W-1:0]            hold_l, hold_r;
    logic                         frame_lat;
    slot_e                        rx_slot;
    logic                         slot_load;
    logic [N_OUTS-1:0][WORD_W-1:0] out_word;
    logic [N_OUTS-1:0]            out_sd;

    assign line_in.bck = bck_i;
    assign line_in.ws  = ws_i;
    assign line_in.sd  = sd_i;

    i2s_split_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .line_i  (line_in),
        .ws_o    (ws_s),
        .sd_o    (sd_s),
        .edge_o  (bedge),
        .bck_d_o (bck_o)
    );

    i2s_split_rx #(
        .WORD_W (WORD_W),
        .POS_W  (POS_W)
    ) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (bedge.rise),
        .ws_i     (ws_s),
        .sd_i     (sd_s),
        .hold_l_o (hold_l),
        .hold_r_o (hold_r),
        .latch_o  (frame_lat),
        .slot_o   (rx_slot)
    );

    // Output word select follows the receiver's slot one bit later,
    // updated on the falling bit-clock edge.
    assign slot_load = bedge.fall & (ws_o != logic'(rx_slot));

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_o <= 1'b0;
        end else if (bedge.fall) begin
            ws_o <= logic'(rx_slot);
        end
    end

    assign out_word[0] = hold_l;
    assign out_word[1] = hold_r;

    for (genvar g = 0; g < N_OUTS; g++) begin : g_out
        i2s_split_tx #(
            .WORD_W (WORD_W)
        ) u_tx (
            .clk    (clk),
            .rst    (rst),
            .fall_i (bedge.fall),
            .load_i (slot_load),
            .word_i (out_word[g]),
            .sd_o   (out_sd[g])
        );
    end

    assign sd_lmono_o = out_sd[0];
    assign sd_rmono_o = out_sd[1];

endmodule

// File: rtl/i2s_split_chk.sv
module i2s_split_chk (
    input logic clk,
    input logic rst,
    input logic bck_o,
    input logic ws_o,
    input logic sd_l,
    input logic sd_r,
    input logic frame_lat
);

    logic seen_frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_frame <= 1'b0;
        end else if (frame_lat) begin
            seen_frame <= 1'b1;
        end
    end

    // R4: word select moves only with a falling output bit clock
    a_r4_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_o) |-> $fell(bck_o));

    // R4: left-mono data moves only with a falling output bit clock
    a_r4_sdl_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_l) |-> $fell(bck_o));

    // R4: right-mono data moves only with a falling output bit clock
    a_r4_sdr_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_r) |-> $fell(bck_o));

    // R6: nothing but zeros leaves the block before a frame is held
    a_r6_zero_before_frame: assert property (@(posedge clk) disable iff (rst)
        !seen_frame |-> (!sd_l && !sd_r));

endmodule

bind i2s_mono_split i2s_split_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bck_o     (bck_o),
    .ws_o      (ws_o),
    .sd_l      (sd_lmono_o),
    .sd_r      (sd_rmono_o),
    .frame_lat (frame_lat)
);

// File: tb/sim_i2s_mono_split.sv
module sim_i2s_mono_split;

    localparam int HALF_BCK = 4;     // system clocks per bit-clock half
    localparam int MAXREC   = 128;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck_i = 1'b0;
    logic ws_i = 1'b1;
    logic sd_i = 1'b0;
    logic bck_o, ws_o, sd_lmono_o, sd_rmono_o;

    always #4 clk = ~clk;   // 125 MHz

    i2s_mono_split u0 (
        .clk        (clk),
        .rst        (rst),
        .bck_i      (bck_i),
        .ws_i       (ws_i),
        .sd_i       (sd_i),
        .bck_o      (bck_o),
        .ws_o       (ws_o),
        .sd_lmono_o (sd_lmono_o),
        .sd_rmono_o (sd_rmono_o)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // stimulus bookkeeping
    logic        prev_bit = 1'b0;
    logic [15:0] in_l [64];
    logic [15:0] in_r [64];

    // decoder of the output streams
    int          dn;
    logic        dch [MAXREC];
    logic [15:0] dwa [MAXREC];
    logic [15:0] dwb [MAXREC];
    logic        dex [MAXREC];
    logic        d_start, d_wsp, d_bckp, d_extra;
    int          d_cnt;
    logic [15:0] d_a, d_b;
    // edge-rule monitor
    logic        m_bck, m_ws, m_sl, m_sr;
    int          edge_viol;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            dn = 0; d_start = 0; d_wsp = 0; d_bckp = 0; d_extra = 0;
            d_cnt = 0; d_a = 0; d_b = 0;
            m_bck = 0; m_ws = 0; m_sl = 0; m_sr = 0;
        end else begin
            if (bck_o && !d_bckp) begin
                if (d_cnt < 16) begin
                    d_a = {d_a[14:0], sd_lmono_o};
                    d_b = {d_b[14:0], sd_rmono_o};
                end else if (sd_lmono_o || sd_rmono_o) begin
                    d_extra = 1'b1;
                end
                if (ws_o !== d_wsp) begin
                    if (d_start && dn < MAXREC) begin
                        dch[dn] = d_wsp; dwa[dn] = d_a; dwb[dn] = d_b; dex[dn] = d_extra;
                        dn++;
                    end
                    d_start = 1'b1; d_cnt = 0; d_a = 0; d_b = 0; d_extra = 0;
                end else if (d_cnt < 1000) begin
                    d_cnt++;
                end
                d_wsp = ws_o;
            end
            d_bckp = bck_o;
            if ((ws_o !== m_ws || sd_lmono_o !== m_sl || sd_rmono_o !== m_sr) &&
                !(m_bck === 1'b1 && bck_o === 1'b0)) begin
                edge_viol++;
            end
            m_bck = bck_o; m_ws = ws_o; m_sl = sd_lmono_o; m_sr = sd_rmono_o;
        end
    end

    // one bit period: the previous bit goes out while ws names the next bit's slot
    task automatic put_bit(input logic b, input logic ch);
        bck_i = 1'b0;
        sd_i  = prev_bit;
        ws_i  = ch;
        repeat (HALF_BCK) @(negedge clk);
        bck_i = 1'b1;
        repeat (HALF_BCK) @(negedge clk);
        prev_bit = b;
    endtask

    task automatic send_slot(input logic [15:0] w, input logic ch, input int slen, input logic pad);
        for (int i = 0; i < slen; i++) begin
            put_bit((i < 16) ? w[15-i] : pad, ch);
        end
    endtask

    task automatic start_run();
        @(negedge clk);
        rst = 1'b1; bck_i = 1'b0; ws_i = 1'b1; sd_i = 1'b0; prev_bit = 1'b0;
        edge_viol = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        send_slot(16'h0000, 1'b1, 8, 1'b0);   // idle right slot before frame 0
    endtask

    task automatic send_frames(input int n, input int slen, input logic pad);
        for (int f = 0; f < n; f++) begin
            send_slot(in_l[f], 1'b0, slen, pad);
            send_slot(in_r[f], 1'b1, slen, pad);
        end
        for (int f = 0; f < 3; f++) begin
            send_slot(16'h0000, 1'b0, slen, 1'b0);
            send_slot(16'h0000, 1'b1, slen, 1'b0);
        end
        put_bit(1'b0, 1'b0);
        repeat (40) @(negedge clk);
    endtask

    // output frame j carries input frame j-1; frame 0 carries zeros
    task automatic check_frames(input string tag, input int n);
        int first;
        first = -1;
        for (int i = 0; i < dn; i++) begin
            if (first < 0 && dch[i] == 1'b0) first = i;
        end
        chk({tag, " R1 decoded left slot found"}, (first >= 0) ? 1 : 0, 1);
        if (first < 0) return;
        for (int j = 0; j <= n; j++) begin
            int li;
            int ri;
            logic [15:0] el;
            logic [15:0] er;
            li = first + 2 * j;
            ri = li + 1;
            el = (j == 0) ? 16'h0000 : in_l[j-1];
            er = (j == 0) ? 16'h0000 : in_r[j-1];
            chk({tag, " R3 output frame present"}, (ri < dn) ? 1 : 0, 1);
            if (ri >= dn) return;
            chk({tag, " R1 slot order"}, {dch[li], dch[ri]}, 2'b01);
            if (j == 0) begin
                chk({tag, " R6 first frame zero A"}, {dwa[li], dwa[ri]}, 32'h0);
                chk({tag, " R6 first frame zero B"}, {dwb[li], dwb[ri]}, 32'h0);
            end else begin
                chk({tag, " R1 R3 left word in A left slot"},  dwa[li], el);
                chk({tag, " R1 R3 left word in A right slot"}, dwa[ri], el);
                chk({tag, " R2 R3 right word in B left slot"},  dwb[li], er);
                chk({tag, " R2 R3 right word in B right slot"}, dwb[ri], er);
            end
            chk({tag, " R5 zero padding on outputs"}, {dex[li], dex[ri]}, 2'b00);
        end
        chk({tag, " R4 outputs move only on falling bck_o"}, edge_viol, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 reset state during reset", {bck_o, ws_o, sd_lmono_o, sd_rmono_o}, 4'b0000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 reset state after release", {bck_o, ws_o, sd_lmono_o, sd_rmono_o}, 4'b0000);
        bck_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 bck_o follows bck_i", bck_o, 1'b1);
    endtask

    task automatic t_random_16();
        for (int f = 0; f < 16; f++) begin
            in_l[f] = 16'($urandom);
            in_r[f] = 16'($urandom);
        end
        in_l[0] = 16'h1234; in_r[0] = 16'hFEDC;
        start_run();
        send_frames(16, 16, 1'b0);
        check_frames("R7 16-bit slots", 16);
    endtask

    task automatic t_corner_32();
        in_l[0] = 16'h8000; in_r[0] = 16'h0001;
        in_l[1] = 16'hFFFF; in_r[1] = 16'h0000;
        in_l[2] = 16'hAAAA; in_r[2] = 16'h5555;
        in_l[3] = 16'h0001; in_r[3] = 16'h8000;
        in_l[4] = 16'h0000; in_r[4] = 16'hFFFF;
        start_run();
        send_frames(5, 32, 1'b0);
        check_frames("corner words 32-bit slots", 5);
    endtask

    task automatic t_padded_24();
        for (int f = 0; f < 12; f++) begin
            in_l[f] = 16'($urandom);
            in_r[f] = ~in_l[f];
        end
        start_run();
        send_frames(12, 24, 1'b1);   // padding bits all ones
        check_frames("R5 24-bit slots with ones padding", 12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired before all scenarios finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_random_16();
        t_corner_32();
        t_padded_24();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule